// File: doc/BRIEF.md
# One-Wire ROM Command Layer

This block is the device-selection stage of a one-wire slave. A time-slot front end turns the analog line into single-cycle bit events. It also flags each bus reset. After every bus reset the layer collects an 8-bit ROM command, least significant bit first. It then runs one of four selection functions against a 64-bit identity held in parameters: read, match, search or skip. When a function completes, the `selected` flag rises, and the memory layer behind this block takes over the bus.

Whenever `tx_req` is high, the next slot is a read slot. In that slot the front end releases the line when `tx_bit` is 1 and pulls it low when `tx_bit` is 0. The line is open-drain, so several devices answering in the same slot produce the AND of their bits. The search function uses this: in each bit it sends the true bit, then its complement, then reads the master's chosen direction, and it drops out if that direction is not its own bit.

The identity image holds, from bit 0 upward, an 8-bit family code (default 02h), a 48-bit serial number and an 8-bit check byte. By default the check byte is computed at elaboration. After the block's own reset, a serial checker runs the whole image through the check polynomial and reports the result on `rom_crc_ok`.

Top module: `onew_rom_layer`

## Requirements
- R1: After `rst`, `selected` and `tx_req` are 0. Bit events arriving before the first `reset_seen` pulse are ignored.
- R2: After `reset_seen`, eight `rx_bit_valid` events form the command byte, least significant bit first. The command codes are 33h read, 55h match, CCh skip and F0h search.
- R3: The image's check byte uses the polynomial x^8+x^5+x^4+1. The register starts at zero, is shifted right, and XORs 8Ch when (register bit 0 XOR input bit) is 1. The bits enter from image bit 0 upward. `rom_crc_ok` is 0 right after `rst` and is 1 from 64 cycles after reset release when all 64 image bits leave the register at zero. It stays 0 otherwise.
- R4: Read (33h) raises `tx_req` and presents image bit i on `tx_bit` for slot i, for i from 0 to 63. `selected` rises after the 64th slot.
- R5: Match (55h) compares 64 received bits with image bits 0 to 63. When all 64 bits are equal, `selected` rises after the 64th bit.
- R6: On a match mismatch, the block goes idle. `tx_req` and `selected` then stay 0, and all further bits, including a full command byte, are ignored until `reset_seen`.
- R7: Skip (CCh) raises `selected` in the cycle after the 8th command bit.
- R8: Search (F0h) sends three slots for each image bit i: the bit with `tx_req`=1, its complement with `tx_req`=1, and then a receive slot with `tx_req`=0 that takes the master's direction. If all 64 directions match, `selected` rises.
- R9: In search, a direction bit that differs from the image bit makes the block idle. `tx_req` then stays 0 until `reset_seen`.
- R10: Any command byte other than the four codes makes the block idle until `reset_seen`.
- R11: `reset_seen` at any point clears `selected` and `tx_req` and restarts command reception at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_seen | input | 1 | One-cycle pulse on a detected bus reset |
| rx_bit_valid | input | 1 | One-cycle pulse at the end of each time slot |
| rx_bit | input | 1 | Line value sampled in that slot |
| tx_req | output | 1 | Next slot is a read slot driven by this device |
| tx_bit | output | 1 | Bit to present in that read slot (1 = release) |
| selected | output | 1 | Device selected; memory layer owns the bus |
| rom_crc_ok | output | 1 | Stored image passed its power-up check |

## Verification
Every selection result (`tx_req`, `tx_bit`, `selected`) comes from the state register. It is due in the cycle after the `rx_bit_valid` or `reset_seen` pulse that causes it. The bench applies each slot pulse on a falling edge, drops it on the next falling edge, and samples outputs only there, one full register stage after the pulse. `rom_crc_ok` has a 64-cycle latency from reset release, so the bench checks it as 0 in the first cycle and reads it only after 70 cycles. A second instance built with a corrupted check byte confirms that the flag stays low.

// File: rtl/onew_pkg.sv
package onew_pkg;

    localparam int ROM_BITS = 64;
    localparam int IDX_W    = $clog2(ROM_BITS);
    localparam int CMD_BITS = 8;

    localparam logic [7:0] CMD_READ   = 8'h33;
    localparam logic [7:0] CMD_MATCH  = 8'h55;
    localparam logic [7:0] CMD_SKIP   = 8'hCC;
    localparam logic [7:0] CMD_SEARCH = 8'hF0;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SRCH_TRUE,
        ST_SRCH_CPL,
        ST_SRCH_DIR,
        ST_SEL
    } seq_state_e;

    // One bit into the reflected x^8+x^5+x^4+1 register.
    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return {1'b0, c[7:1]} ^ (fb ? 8'h8C : 8'h00);
    endfunction

    function automatic logic [7:0] crc8_over56(input logic [55:0] d);
        logic [7:0] c;
        c = 8'h00;
        for (int i = 0; i < 56; i++) c = crc8_step(c, d[i]);
        return c;
    endfunction

    function automatic seq_state_e cmd_next(input logic [7:0] code);
        case (code)
            CMD_READ:   return ST_READ;
            CMD_MATCH:  return ST_MATCH;
            CMD_SKIP:   return ST_SEL;
            CMD_SEARCH: return ST_SRCH_TRUE;
            default:    return ST_HALT;
        endcase
    endfunction

endpackage

// File: rtl/onew_crc_check.sv
module onew_crc_check
    import onew_pkg::*;
#(
    parameter logic [ROM_BITS-1:0] IMAGE = '0
) (
    input  logic clk,
    input  logic rst,
    output logic crc_ok
);
    logic [IDX_W-1:0] pos;
    logic [7:0]       crc;
    logic             done;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos  <= '0;
            crc  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            crc <= crc8_step(crc, IMAGE[pos]);
            pos <= pos + 1'b1;
            if (pos == IDX_W'(ROM_BITS - 1)) done <= 1'b1;
        end
    end

    assign crc_ok = done && (crc == 8'h00);
endmodule

// File: rtl/onew_rom_seq.sv
module onew_rom_seq
    import onew_pkg::*;
#(
    parameter logic [ROM_BITS-1:0] IMAGE = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic reset_seen,
    input  logic rx_bit_valid,
    input  logic rx_bit,
    output logic tx_req,
    output logic tx_bit,
    output logic selected
);
    seq_state_e       state;
    logic [IDX_W-1:0] idx;
    logic [6:0]       cmd_sr;
    logic             img_bit;
    logic             last;

    assign img_bit = IMAGE[idx];
    assign last    = (idx == IDX_W'(ROM_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_HALT;
            idx    <= '0;
            cmd_sr <= '0;
        end else if (reset_seen) begin
            state <= ST_CMD;
            idx   <= '0;
        end else if (rx_bit_valid) begin
            case (state)
                ST_CMD: begin
                    cmd_sr <= {rx_bit, cmd_sr[6:1]};
                    if (idx == IDX_W'(CMD_BITS - 1)) begin
                        idx   <= '0;
                        state <= cmd_next({rx_bit, cmd_sr});
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_READ: begin
                    if (last) state <= ST_SEL;
                    else      idx   <= idx + 1'b1;
                end
                ST_MATCH: begin
                    if (rx_bit != img_bit) state <= ST_HALT;
                    else if (last)         state <= ST_SEL;
                    else                   idx   <= idx + 1'b1;
                end
                ST_SRCH_TRUE: state <= ST_SRCH_CPL;
                ST_SRCH_CPL:  state <= ST_SRCH_DIR;
                ST_SRCH_DIR: begin
                    if (rx_bit != img_bit) state <= ST_HALT;
                    else if (last)         state <= ST_SEL;
                    else begin
                        idx   <= idx + 1'b1;
                        state <= ST_SRCH_TRUE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        tx_req = 1'b0;
        tx_bit = 1'b1;
        case (state)
            ST_READ, ST_SRCH_TRUE: begin tx_req = 1'b1; tx_bit = img_bit;  end
            ST_SRCH_CPL:           begin tx_req = 1'b1; tx_bit = ~img_bit; end
            default: ;
        endcase
    end

    assign selected = (state == ST_SEL);
endmodule

// File: rtl/onew_rom_layer.sv
module onew_rom_layer
    import onew_pkg::*;
#(
    parameter logic [7:0]  FAMILY_CODE = 8'h02,
    parameter logic [47:0] SERIAL_NUM  = 48'h5A3C_91E7_0D24,
    parameter logic [7:0]  ROM_CRC     = crc8_over56({SERIAL_NUM, FAMILY_CODE})
) (
    input  logic clk,
    input  logic rst,
    input  logic reset_seen,
    input  logic rx_bit_valid,
    input  logic rx_bit,
    output logic tx_req,
    output logic tx_bit,
    output logic selected,
    output logic rom_crc_ok
);
    localparam logic [ROM_BITS-1:0] IMAGE = {ROM_CRC, SERIAL_NUM, FAMILY_CODE};

    onew_rom_seq #(.IMAGE(IMAGE)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .reset_seen   (reset_seen),
        .rx_bit_valid (rx_bit_valid),
        .rx_bit       (rx_bit),
        .tx_req       (tx_req),
        .tx_bit       (tx_bit),
        .selected     (selected)
    );

    onew_crc_check #(.IMAGE(IMAGE)) u_crc (
        .clk    (clk),
        .rst    (rst),
        .crc_ok (rom_crc_ok)
    );
endmodule

// File: rtl/onew_rom_layer_chk.sv
module onew_rom_layer_chk (
    input logic clk,
    input logic rst,
    input logic reset_seen,
    input logic rx_bit_valid,
    input logic tx_req,
    input logic selected,
    input logic rom_crc_ok
);
    logic past_ok;
    always_ff @(posedge clk) past_ok <= !rst;

    a_r1_idle_after_rst: assert property (@(posedge clk)
        rst |=> (!selected && !tx_req));

    a_r11_reset_deselects: assert property (@(posedge clk) disable iff (rst)
        reset_seen |=> (!selected && !tx_req));

    a_r7_select_needs_slot: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $rose(selected)) |-> $past(rx_bit_valid));

    a_r3_crc_ok_sticky: assert property (@(posedge clk) disable iff (rst)
        rom_crc_ok |=> rom_crc_ok);

    a_r5_selected_holds: assert property (@(posedge clk) disable iff (rst)
        (selected && !reset_seen) |=> selected);

    a_r8_tx_moves_on_slot: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(rx_bit_valid) && !$past(reset_seen)) |-> $stable(tx_req));
endmodule

bind onew_rom_layer onew_rom_layer_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .reset_seen   (reset_seen),
    .rx_bit_valid (rx_bit_valid),
    .tx_req       (tx_req),
    .selected     (selected),
    .rom_crc_ok   (rom_crc_ok)
);

// File: tb/onew_rom_layer_bench.sv
module onew_rom_layer_bench;
    localparam logic [7:0]  FAM = 8'h02;
    localparam logic [47:0] SER = 48'h5A3C_91E7_0D24;

    function automatic logic [7:0] ref_crc(input logic [55:0] d);
        logic [7:0] c;
        c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            logic fb;
            fb = c[0] ^ d[i];
            c  = c >> 1;
            if (fb) c = c ^ 8'h8C;
        end
        return c;
    endfunction

    localparam logic [7:0]  GOOD_CRC = ref_crc({SER, FAM});
    localparam logic [63:0] ROM      = {GOOD_CRC, SER, FAM};

    // {command, expected tx_req, expected selected, expected tx_bit}
    localparam logic [10:0] VEC [0:5] = '{
        {8'h33, 1'b1, 1'b0, 1'b0},
        {8'h55, 1'b0, 1'b0, 1'b1},
        {8'hCC, 1'b0, 1'b1, 1'b1},
        {8'hF0, 1'b1, 1'b0, 1'b0},
        {8'h00, 1'b0, 1'b0, 1'b1},
        {8'hA5, 1'b0, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reset_seen = 1'b0;
    logic rx_bit_valid = 1'b0;
    logic rx_bit = 1'b0;
    logic tx_req, tx_bit, selected, rom_crc_ok;
    logic b_tx_req, b_tx_bit, b_selected, b_crc_ok;
    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    onew_rom_layer #(.FAMILY_CODE(FAM), .SERIAL_NUM(SER)) u_onew_rom_layer (
        .clk(clk), .rst(rst), .reset_seen(reset_seen), .rx_bit_valid(rx_bit_valid),
        .rx_bit(rx_bit), .tx_req(tx_req), .tx_bit(tx_bit), .selected(selected),
        .rom_crc_ok(rom_crc_ok));

    onew_rom_layer #(.FAMILY_CODE(FAM), .SERIAL_NUM(SER), .ROM_CRC(GOOD_CRC ^ 8'h01)) u_bad_crc (
        .clk(clk), .rst(rst), .reset_seen(1'b0), .rx_bit_valid(1'b0),
        .rx_bit(1'b0), .tx_req(b_tx_req), .tx_bit(b_tx_bit), .selected(b_selected),
        .rom_crc_ok(b_crc_ok));

    task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic slot(input logic b);
        rx_bit = b;
        rx_bit_valid = 1'b1;
        @(negedge clk);
        rx_bit_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_reset();
        reset_seen = 1'b1;
        @(negedge clk);
        reset_seen = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) slot(v[i]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state, R3 flag low immediately after reset
        chk(!selected && !tx_req, "R1 reset outputs", {selected, tx_req}, 8'h0);
        chk(!rom_crc_ok, "R3 crc flag early", rom_crc_ok, 8'h0);
        // R1: a skip byte before any bus reset is ignored
        send_byte(8'hCC);
        chk(!selected, "R1 ignored before reset_seen", selected, 8'h0);
        repeat (70) @(negedge clk);
        chk(rom_crc_ok, "R3 good image", rom_crc_ok, 8'h1);
        chk(!b_crc_ok, "R3 corrupted image", b_crc_ok, 8'h0);

        // R2 / R10 table walk
        for (int v = 0; v < 6; v++) begin
            bus_reset();
            send_byte(VEC[v][10:3]);
            chk(tx_req == VEC[v][2] && selected == VEC[v][1] && (!tx_req || tx_bit == VEC[v][0]),
                $sformatf("R2 command %0h", VEC[v][10:3]), {tx_req, selected, tx_bit},
                {VEC[v][2], VEC[v][1], VEC[v][0]});
        end

        // R4 read whole image
        bus_reset();
        send_byte(8'h33);
        bad = 0;
        for (int i = 0; i < 64; i++) begin
            if (!tx_req || tx_bit != ROM[i]) bad++;
            slot(1'b1);
        end
        chk(bad == 0, "R4 read bits", 8'(bad), 8'h0);
        chk(selected && !tx_req, "R4 selected after read", {selected, tx_req}, 8'h2);

        // R11 reset mid-read
        bus_reset();
        send_byte(8'h33);
        repeat (5) slot(1'b1);
        bus_reset();
        chk(!tx_req && !selected, "R11 abort read", {tx_req, selected}, 8'h0);
        send_byte(8'hCC);
        chk(selected, "R7 skip after abort", selected, 8'h1);
        bus_reset();
        chk(!selected, "R11 deselect", selected, 8'h0);

        // R5 full match
        send_byte(8'h55);
        for (int i = 0; i < 63; i++) slot(ROM[i]);
        chk(!selected, "R5 not yet at bit 63", selected, 8'h0);
        slot(ROM[63]);
        chk(selected, "R5 match", selected, 8'h1);

        // R6 mismatch at bit 40
        bus_reset();
        send_byte(8'h55);
        for (int i = 0; i < 40; i++) slot(ROM[i]);
        slot(~ROM[40]);
        for (int i = 41; i < 64; i++) slot(ROM[i]);
        chk(!selected && !tx_req, "R6 mismatch idle", {selected, tx_req}, 8'h0);
        send_byte(8'hCC);
        chk(!selected, "R6 later skip ignored", selected, 8'h0);
        send_byte(8'h33);
        chk(!tx_req, "R6 later read ignored", tx_req, 8'h0);

        // R8 full search pass
        bus_reset();
        send_byte(8'hF0);
        bad = 0;
        for (int i = 0; i < 64; i++) begin
            if (!tx_req || tx_bit != ROM[i]) bad++;
            slot(ROM[i]);
            if (!tx_req || tx_bit != ~ROM[i]) bad++;
            slot(ROM[i]);
            if (tx_req) bad++;
            slot(ROM[i]);
        end
        chk(bad == 0, "R8 search triplets", 8'(bad), 8'h0);
        chk(selected, "R8 search selects", selected, 8'h1);

        // R9 search drop-out at bit 10
        bus_reset();
        send_byte(8'hF0);
        for (int i = 0; i < 10; i++) begin
            slot(ROM[i]); slot(~ROM[i]); slot(ROM[i]);
        end
        slot(ROM[10]); slot(~ROM[10]); slot(~ROM[10]);
        chk(!tx_req, "R9 drop-out", tx_req, 8'h0);
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            slot(1'b1);
            if (tx_req || selected) bad++;
        end
        chk(bad == 0, "R9 stays out", 8'(bad), 8'h0);

        // R10 unknown command then recovery
        bus_reset();
        send_byte(8'h3C);
        send_byte(8'hCC);
        chk(!selected, "R10 unknown stays idle", selected, 8'h0);
        bus_reset();
        send_byte(8'hCC);
        chk(selected, "R10 recovered by reset_seen", selected, 8'h1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule